// File: doc/BRIEF.md
# Thermal Ratio Boost Governor

The governor picks a core clock ratio from two live inputs: how many cores are active and the hottest core temperature. A configuration table holds one row for each possible active core count. Each row gives a base ratio, a first temperature limit with its own programmable ratio penalty, and a second temperature limit whose penalty is always one step. The active count selects the row. The temperature then decides how many steps are taken off that row's base ratio. The result never goes below a programmable minimum ratio.

Two preset modes give one or two extra ratio steps on top of each row's base ratio. In these modes both temperature limits are derived from one programmable base temperature, and the table limits are not used. Alongside the ratio the block reports a voltage-ratio index. This index always follows the un-boosted ratio, so a preset gains frequency without asking for more voltage. A fourth mode code is treated as unsupported. In that mode the block raises a not-available flag and passes the row's base ratio through unchanged. Results are evaluated on an input strobe and held in registers until the next strobe.

Top module: `thermal_ratio_gov`

## Requirements
- R1: With `cnt_valid_i` high and `active_cnt_i` equal to n (1 ≤ n ≤ NUM_CORES), row n-1 of the table applies. Row r occupies bits `[r*W +: W]` of each flattened table input.
- R2: When `temp_i` is strictly greater than the row's limit A, the ratio drops by that row's offset. When `temp_i` equals limit A, nothing is taken off.
- R3: When `temp_i` is strictly greater than limit B, exactly one more ratio step is removed. This step adds to any limit-A penalty.
- R4: When `cnt_valid_i` is low, when the count is 0, or when the count exceeds NUM_CORES, row 0 applies.
- R5: Mode codes are 0 = custom, 1 = boost by one step and 2 = boost by two steps. In modes 1 and 2, `ratio_o` is base + steps, saturated at the largest ratio code, minus the thermal drop. `vid_ratio_o` is base minus the thermal drop. In mode 0 the two outputs are equal.
- R6: In modes 1 and 2, limit A is `preset_temp_i` − 10 × steps, saturating at 0, and limit B is limit A + 10. The table limits are ignored in these modes.
- R7: In modes 0 to 2, both `ratio_o` and `vid_ratio_o` are floored at `min_ratio_i`.
- R8: Mode code 3 is unsupported. It sets `na_o` = 1, and both ratio outputs equal the row's base ratio with no boost, no thermal drop and no floor. All other modes clear `na_o`.
- R9: All outputs take their new value on the clock edge that samples `eval_i` high. They hold their value while `eval_i` is low, whatever the other inputs do.
- R10: While reset is active (`rst_n` low), `ratio_o`, `vid_ratio_o` and `na_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eval_i | input | 1 | Evaluate strobe; outputs update at the next edge |
| cnt_valid_i | input | 1 | Active core count is meaningful |
| active_cnt_i | input | CNT_W | Number of active cores |
| temp_i | input | TEMP_W | Hottest core temperature, degrees C |
| mode_i | input | 2 | 0 custom, 1 boost +1, 2 boost +2, 3 unsupported |
| preset_temp_i | input | TEMP_W | Base temperature for the preset limits |
| min_ratio_i | input | RATIO_W | Lowest allowed ratio |
| cfg_ratio_i | input | NUM_CORES*RATIO_W | Base ratio per row |
| cfg_ofs_i | input | NUM_CORES*OFS_W | Limit-A penalty per row |
| cfg_tha_i | input | NUM_CORES*TEMP_W | Limit A per row (custom mode) |
| cfg_thb_i | input | NUM_CORES*TEMP_W | Limit B per row (custom mode) |
| ratio_o | output | RATIO_W | Selected core ratio |
| vid_ratio_o | output | RATIO_W | Ratio used to look up voltage |
| na_o | output | 1 | Mode not available |

## Verification
Directed temperatures placed just below a limit, exactly on it and just above it show whether the comparisons are strict. They also show whether the two penalties add up, or whether only one is applied. Count patterns cover every valid row, zero, counts above the core count, and a low valid flag. These show the row decode apart from the fallback row. Preset vectors near the saturation points of the limit arithmetic and of the ratio separate the boosted ratio from the voltage index. Random table contents, modes, minimum ratios and temperatures are then checked against a bench model, which exposes interactions between the floor and the penalties.

// File: rtl/trg_pkg.sv
package trg_pkg;

  typedef enum logic [1:0] {
    MODE_CUSTOM = 2'd0,
    MODE_PLUS1  = 2'd1,
    MODE_PLUS2  = 2'd2,
    MODE_NA     = 2'd3
  } trg_mode_e;

  // number of extra ratio steps a mode grants
  function automatic logic [1:0] boost_steps(trg_mode_e m);
    case (m)
      MODE_PLUS1: return 2'd1;
      MODE_PLUS2: return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic is_preset(trg_mode_e m);
    return (m == MODE_PLUS1) || (m == MODE_PLUS2);
  endfunction

endpackage

// File: rtl/trg_row_pick.sv
module trg_row_pick #(
  parameter int NUM_CORES = 8,
  parameter int CNT_W     = 4,
  parameter int ROW_W     = 3
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_valid_i,
  output logic [ROW_W-1:0] row_o,
  output logic             fallback_o
);

  logic             hit;
  logic [ROW_W-1:0] dec_row;

  // decode count n -> row n-1, only for counts that name a real row
  always_comb begin
    hit     = 1'b0;
    dec_row = '0;
    for (int r = 0; r < NUM_CORES; r++) begin
      if (cnt_i == CNT_W'(r + 1)) begin
        hit     = 1'b1;
        dec_row = ROW_W'(r);
      end
    end
  end

  assign fallback_o = !(cnt_valid_i && hit);
  assign row_o      = fallback_o ? '0 : dec_row;

endmodule

// File: rtl/trg_thresh.sv
module trg_thresh
  import trg_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int THR_STEP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trg_mode_e         mode_i,
  input  logic [TEMP_W-1:0] cfg_a_i,
  input  logic [TEMP_W-1:0] cfg_b_i,
  input  logic [TEMP_W-1:0] base_temp_i,
  output logic [TEMP_W-1:0] th_a_o,
  output logic [TEMP_W-1:0] th_b_o
);

  localparam int XT = TEMP_W + 3;

  // base minus steps*THR_STEP, clipped at zero
  function automatic logic [TEMP_W-1:0] lower_sat(logic [TEMP_W-1:0] a,
                                                  logic [1:0] steps);
    logic [XT-1:0] cut;
    cut = XT'(steps) * XT'(THR_STEP);
    if (XT'(a) <= cut) return '0;
    return TEMP_W'(XT'(a) - cut);
  endfunction

  // value plus THR_STEP, clipped at the top code
  function automatic logic [TEMP_W-1:0] raise_sat(logic [TEMP_W-1:0] a);
    logic [XT-1:0] sum;
    sum = XT'(a) + XT'(THR_STEP);
    if (sum > XT'({TEMP_W{1'b1}})) return '1;
    return TEMP_W'(sum);
  endfunction

  logic [TEMP_W-1:0] preset_a;

  assign preset_a = lower_sat(base_temp_i, boost_steps(mode_i));
  assign th_a_o   = is_preset(mode_i) ? preset_a            : cfg_a_i;
  assign th_b_o   = is_preset(mode_i) ? raise_sat(preset_a) : cfg_b_i;

  // R6
  preset_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_preset(mode_i) |-> (th_b_o >= th_a_o) && (th_a_o <= base_temp_i));

endmodule

// File: rtl/trg_ratio_calc.sv
module trg_ratio_calc
  import trg_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int TEMP_W  = 8,
  parameter int OFS_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  trg_mode_e          mode_i,
  input  logic [RATIO_W-1:0] base_i,
  input  logic [OFS_W-1:0]   ofs_i,
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic [TEMP_W-1:0]  th_a_i,
  input  logic [TEMP_W-1:0]  th_b_i,
  input  logic [RATIO_W-1:0] min_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [RATIO_W-1:0] vid_o,
  output logic               na_o,
  output logic               hot_a_o,
  output logic               hot_b_o
);

  localparam int XW = RATIO_W + OFS_W + 2;
  localparam logic [XW-1:0] MAXR = XW'({RATIO_W{1'b1}});

  // a - d, but never below floor m
  function automatic logic [RATIO_W-1:0] floor_sub(logic [XW-1:0] a,
                                                   logic [XW-1:0] d,
                                                   logic [RATIO_W-1:0] m);
    if (a < d + XW'(m)) return m;
    return RATIO_W'(a - d);
  endfunction

  // base + steps, clipped at the top ratio code
  function automatic logic [XW-1:0] boost_sat(logic [RATIO_W-1:0] b,
                                              logic [1:0] s);
    logic [XW-1:0] sum;
    sum = XW'(b) + XW'(s);
    return (sum > MAXR) ? MAXR : sum;
  endfunction

  logic [1:0]    steps;
  logic [XW-1:0] drop;

  assign steps   = boost_steps(mode_i);
  assign hot_a_o = temp_i > th_a_i;
  assign hot_b_o = temp_i > th_b_i;
  assign drop    = (hot_a_o ? XW'(ofs_i) : '0) + (hot_b_o ? XW'(1) : '0);

  always_comb begin
    if (mode_i == MODE_NA) begin
      ratio_o = base_i;
      vid_o   = base_i;
      na_o    = 1'b1;
    end else begin
      ratio_o = floor_sub(boost_sat(base_i, steps), drop, min_i);
      vid_o   = floor_sub(XW'(base_i), drop, min_i);
      na_o    = 1'b0;
    end
  end

  // R5
  boost_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_NA) |->
      (ratio_o >= vid_o) &&
      (({1'b0, ratio_o} - {1'b0, vid_o}) <= (RATIO_W+1)'(steps)));

  // R3
  b_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_NA && hot_b_o && !hot_a_o && base_i > min_i) |->
      (vid_o == base_i - RATIO_W'(1)));

endmodule

// File: rtl/thermal_ratio_gov.sv
module thermal_ratio_gov
  import trg_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int RATIO_W   = 8,
  parameter int TEMP_W    = 8,
  parameter int OFS_W     = 3,
  parameter int THR_STEP  = 10,
  parameter int CNT_W     = $clog2(NUM_CORES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          eval_i,
  input  logic                          cnt_valid_i,
  input  logic [CNT_W-1:0]              active_cnt_i,
  input  logic [TEMP_W-1:0]             temp_i,
  input  logic [1:0]                    mode_i,
  input  logic [TEMP_W-1:0]             preset_temp_i,
  input  logic [RATIO_W-1:0]            min_ratio_i,
  input  logic [NUM_CORES*RATIO_W-1:0]  cfg_ratio_i,
  input  logic [NUM_CORES*OFS_W-1:0]    cfg_ofs_i,
  input  logic [NUM_CORES*TEMP_W-1:0]   cfg_tha_i,
  input  logic [NUM_CORES*TEMP_W-1:0]   cfg_thb_i,
  output logic [RATIO_W-1:0]            ratio_o,
  output logic [RATIO_W-1:0]            vid_ratio_o,
  output logic                          na_o
);

  localparam int ROW_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  trg_mode_e mode;
  assign mode = trg_mode_e'(mode_i);

  // unpack the flattened table into per-row arrays
  logic [RATIO_W-1:0] row_ratio [NUM_CORES];
  logic [OFS_W-1:0]   row_ofs   [NUM_CORES];
  logic [TEMP_W-1:0]  row_tha   [NUM_CORES];
  logic [TEMP_W-1:0]  row_thb   [NUM_CORES];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_row
    assign row_ratio[g] = cfg_ratio_i[g*RATIO_W +: RATIO_W];
    assign row_ofs[g]   = cfg_ofs_i[g*OFS_W +: OFS_W];
    assign row_tha[g]   = cfg_tha_i[g*TEMP_W +: TEMP_W];
    assign row_thb[g]   = cfg_thb_i[g*TEMP_W +: TEMP_W];
  end

  logic [ROW_W-1:0]   row_idx;
  logic               row_fallback;
  logic [TEMP_W-1:0]  th_a, th_b;
  logic [RATIO_W-1:0] nxt_ratio, nxt_vid;
  logic               nxt_na, hot_a, hot_b;

  trg_row_pick #(
    .NUM_CORES (NUM_CORES),
    .CNT_W     (CNT_W),
    .ROW_W     (ROW_W)
  ) u_row_pick (
    .cnt_i       (active_cnt_i),
    .cnt_valid_i (cnt_valid_i),
    .row_o       (row_idx),
    .fallback_o  (row_fallback)
  );

  trg_thresh #(
    .TEMP_W   (TEMP_W),
    .THR_STEP (THR_STEP)
  ) u_thresh (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .cfg_a_i     (row_tha[row_idx]),
    .cfg_b_i     (row_thb[row_idx]),
    .base_temp_i (preset_temp_i),
    .th_a_o      (th_a),
    .th_b_o      (th_b)
  );

  trg_ratio_calc #(
    .RATIO_W (RATIO_W),
    .TEMP_W  (TEMP_W),
    .OFS_W   (OFS_W)
  ) u_calc (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode),
    .base_i  (row_ratio[row_idx]),
    .ofs_i   (row_ofs[row_idx]),
    .temp_i  (temp_i),
    .th_a_i  (th_a),
    .th_b_i  (th_b),
    .min_i   (min_ratio_i),
    .ratio_o (nxt_ratio),
    .vid_o   (nxt_vid),
    .na_o    (nxt_na),
    .hot_a_o (hot_a),
    .hot_b_o (hot_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_o     <= '0;
      vid_ratio_o <= '0;
      na_o        <= 1'b0;
    end else if (eval_i) begin
      ratio_o     <= nxt_ratio;
      vid_ratio_o <= nxt_vid;
      na_o        <= nxt_na;
    end
  end

  // R4
  fallback_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_fallback |-> (row_idx == '0));

  // R2
  hot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_preset(mode) && hot_b) |-> hot_a);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(eval_i) |-> $stable(ratio_o) && $stable(vid_ratio_o) && $stable(na_o));

  // R7
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eval_i) && !na_o) |->
      (ratio_o >= $past(min_ratio_i)) && (vid_ratio_o >= $past(min_ratio_i)));

  // R8
  na_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    na_o |-> (ratio_o == vid_ratio_o));

  // R5
  custom_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eval_i) && $past(mode_i) == 2'd0) |-> (ratio_o == vid_ratio_o));

endmodule

// File: tb/thermal_ratio_gov_bench.sv
module thermal_ratio_gov_bench;

  localparam int NC = 8;
  localparam int RW = 8;
  localparam int TW = 8;
  localparam int OW = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eval_i = 1'b0;
  logic cnt_valid_i = 1'b0;
  logic [CW-1:0] active_cnt_i = '0;
  logic [TW-1:0] temp_i = '0;
  logic [1:0] mode_i = '0;
  logic [TW-1:0] preset_temp_i = '0;
  logic [RW-1:0] min_ratio_i = '0;
  logic [NC*RW-1:0] cfg_ratio_i;
  logic [NC*OW-1:0] cfg_ofs_i;
  logic [NC*TW-1:0] cfg_tha_i;
  logic [NC*TW-1:0] cfg_thb_i;
  logic [RW-1:0] ratio_o, vid_ratio_o;
  logic na_o;

  logic [RW-1:0] t_ratio [NC];
  logic [OW-1:0] t_ofs [NC];
  logic [TW-1:0] t_tha [NC];
  logic [TW-1:0] t_thb [NC];

  always_comb begin
    for (int r = 0; r < NC; r++) begin
      cfg_ratio_i[r*RW +: RW] = t_ratio[r];
      cfg_ofs_i[r*OW +: OW]   = t_ofs[r];
      cfg_tha_i[r*TW +: TW]   = t_tha[r];
      cfg_thb_i[r*TW +: TW]   = t_thb[r];
    end
  end

  thermal_ratio_gov u_thermal_ratio_gov (
    .clk (clk), .rst_n (rst_n), .eval_i (eval_i),
    .cnt_valid_i (cnt_valid_i), .active_cnt_i (active_cnt_i),
    .temp_i (temp_i), .mode_i (mode_i), .preset_temp_i (preset_temp_i),
    .min_ratio_i (min_ratio_i), .cfg_ratio_i (cfg_ratio_i),
    .cfg_ofs_i (cfg_ofs_i), .cfg_tha_i (cfg_tha_i), .cfg_thb_i (cfg_thb_i),
    .ratio_o (ratio_o), .vid_ratio_o (vid_ratio_o), .na_o (na_o)
  );

  always #5 clk = ~clk;

  int nvec = 0;
  int nfail = 0;
  logic [16:0] last_exp = '0;

  // expected {na, vid, ratio} written straight from the requirements
  function automatic logic [16:0] model(int cnt, bit vld, int temp, int md,
                                        int bt, int mn);
    int row, base, la, lb, d, r, v, s;
    row  = (vld && cnt >= 1 && cnt <= NC) ? cnt - 1 : 0;
    base = int'(t_ratio[row]);
    if (md == 3) return {1'b1, base[7:0], base[7:0]};
    s = md;
    if (s == 0) begin
      la = int'(t_tha[row]);
      lb = int'(t_thb[row]);
    end else begin
      la = bt - 10 * s;
      if (la < 0) la = 0;
      lb = la + 10;
      if (lb > 255) lb = 255;
    end
    d = 0;
    if (temp > la) d = d + int'(t_ofs[row]);
    if (temp > lb) d = d + 1;
    r = base + s;
    if (r > 255) r = 255;
    r = r - d;
    if (r < mn) r = mn;
    v = base - d;
    if (v < mn) v = mn;
    return {1'b0, v[7:0], r[7:0]};
  endfunction

  task automatic chk(input string req, input logic [16:0] exp);
    nvec++;
    if ({na_o, vid_ratio_o, ratio_o} !== exp) begin
      nfail++;
      $display("FAIL %s: ratio=%0d vid=%0d na=%0d expected ratio=%0d vid=%0d na=%0d",
               req, ratio_o, vid_ratio_o, na_o, exp[7:0], exp[15:8], exp[16]);
    end
  endtask

  // drive at a falling edge, strobe one cycle, check at the next falling edge
  task automatic step(input string req, input int cnt, input bit vld,
                      input int temp, input int md, input int bt, input int mn);
    @(negedge clk);
    active_cnt_i  = CW'(cnt);
    cnt_valid_i   = vld;
    temp_i        = TW'(temp);
    mode_i        = 2'(md);
    preset_temp_i = TW'(bt);
    min_ratio_i   = RW'(mn);
    eval_i        = 1'b1;
    @(negedge clk);
    eval_i   = 1'b0;
    last_exp = model(cnt, vld, temp, md, bt, mn);
    chk(req, last_exp);
  endtask

  task automatic set_row(input int r, input int ra, input int of,
                         input int a, input int b);
    t_ratio[r] = RW'(ra);
    t_ofs[r]   = OW'(of);
    t_tha[r]   = TW'(a);
    t_thb[r]   = TW'(b);
  endtask

  initial begin
    for (int r = 0; r < NC; r++) set_row(r, 40 + r, 1, 70, 80);
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", 17'd0);
    rst_n = 1'b1;

    set_row(0, 55, 1, 68, 78);
    set_row(2, 53, 3, 70, 80);
    // R2 R3 single-core example
    step("R1", 1, 1, 50, 0, 0, 0);
    step("R2", 1, 1, 72, 0, 0, 0);
    step("R2 equal", 1, 1, 68, 0, 0, 0);
    step("R3", 1, 1, 82, 0, 0, 0);
    step("R3 equal", 1, 1, 78, 0, 0, 0);
    // three-core example
    step("R1 row3", 3, 1, 60, 0, 0, 0);
    step("R2 row3", 3, 1, 77, 0, 0, 0);
    step("R3 row3", 3, 1, 87, 0, 0, 0);
    for (int c = 1; c <= NC; c++) step("R1 sweep", c, 1, 20, 0, 0, 0);
    // R4 fallback cases
    step("R4 invalid", 3, 0, 60, 0, 0, 0);
    step("R4 zero", 0, 1, 60, 0, 0, 0);
    step("R4 over", 9, 1, 60, 0, 0, 0);
    step("R4 max", 15, 1, 72, 0, 0, 0);
    // R5 presets
    step("R5 plus1", 1, 1, 50, 1, 90, 0);
    step("R5 plus2", 1, 1, 50, 2, 90, 0);
    // R6 preset limits: base 80, +2 -> A=60, B=70
    step("R6 A equal", 3, 1, 60, 2, 80, 0);
    step("R6 A above", 3, 1, 61, 2, 80, 0);
    step("R6 B above", 3, 1, 71, 2, 80, 0);
    step("R6 A sat", 3, 1, 1, 2, 5, 0);
    step("R6 table ignored", 1, 1, 72, 1, 200, 0);
    set_row(5, 255, 0, 200, 210);
    step("R5 sat", 6, 1, 10, 2, 250, 0);
    // R7 floor
    step("R7 floor", 3, 1, 90, 0, 0, 52);
    step("R7 floor preset", 3, 1, 90, 2, 40, 60);
    step("R7 below base", 1, 1, 10, 0, 0, 70);
    // R8 unsupported mode
    step("R8", 3, 1, 99, 3, 0, 80);
    // R9 hold without strobe
    @(negedge clk);
    temp_i = 8'd5; mode_i = 2'd1; active_cnt_i = 4'd6; min_ratio_i = 8'd0;
    repeat (3) @(negedge clk);
    chk("R9 hold", last_exp);

    // random vectors
    for (int i = 0; i < 400; i++) begin
      if (i % 25 == 0) begin
        for (int r = 0; r < NC; r++) begin
          int a;
          a = 40 + int'($urandom_range(50));
          set_row(r, 20 + int'($urandom_range(60)), int'($urandom_range(7)),
                  a, a + int'($urandom_range(20)));
        end
      end
      step("R1-rand R2 R3", int'($urandom_range(15)), ($urandom_range(7) != 0),
           int'($urandom_range(120)), int'($urandom_range(3)),
           int'($urandom_range(255)), int'($urandom_range(50)));
      if (i % 50 == 7) begin
        @(negedge clk);
        temp_i = TW'($urandom_range(255));
        mode_i = 2'($urandom_range(3));
        @(negedge clk);
        chk("R9 rand hold", last_exp);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule